// File: doc/BRIEF.md
# Bridge Transaction Ordering Queue

This block carries one direction of traffic through a bus-to-bus bridge. The originating side offers one transaction per cycle: either a posted memory write or a delayed (non-posted) request. Posted writes go into a FIFO and are forwarded one by one, exactly as they arrived. Delayed requests are parked in a small set of slots and answered with retry until the destination bus has finished them. A later repeat of the same request then collects the completion data.

The destination side sees a single issue register. It holds one transaction until the destination reports a termination other than retry, and only then is that transaction's place in the order fixed. Posted writes always win the issue register over parked requests. As a result, a delayed completion can never overtake a write that was accepted before it. Because the two directions of a bridge impose no ordering on each other, a bridge uses two independent copies of this block.

Top module: `br_ord_queue`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `out_valid` and `rsp_valid` are 0.
- R2: A posted write (`in_posted`=1) offered while the FIFO holds fewer than `PW_DEPTH` entries is answered with `rsp_code`=2 (accept) and stored. This holds whatever state the delayed-request slots are in.
- R3: A posted write offered while the FIFO holds `PW_DEPTH` entries is answered with `rsp_code`=1 (retry) and discarded.
- R4: Every accepted posted write is presented once on the `out_*` fields, in arrival order, with its own address, command, byte enables and data. Writes to the same address or DWORD are never merged or collapsed.
- R5: When the issue register is empty and the FIFO is not empty, the oldest posted write is issued next. A parked request is issued only when the FIFO is empty.
- R6: A delayed request (`in_posted`=0) that matches no slot is answered with retry. It is stored in the lowest-numbered free slot, if one exists.
- R7: A delayed request that matches no slot while every slot is occupied is answered with retry and is not stored.
- R8: A delayed request matching an occupied slot on address, command and byte enables is answered with retry while that slot's transaction has not yet finished on the destination bus.
- R9: A matching repeat of a request whose transaction has finished is answered with `rsp_code`=3 (complete), with the data returned by the destination in `rsp_data`. The slot is then freed.
- R10: While `out_valid` is 1 and the destination either does not finish the transaction or finishes it with `dst_retry`=1, the `out_*` fields stay unchanged in the next cycle.
- R11: Among parked requests waiting to issue, the search starts at the slot after the one issued last (slot 0 after reset) and wraps around.
- R12: A complete response is never given before every posted write accepted ahead of the original request has finished on the destination bus.
- R13: `rsp_valid` is 1 in exactly the cycle after each cycle in which `in_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A transaction is offered this cycle |
| in_posted | input | 1 | 1 = posted write, 0 = delayed request |
| in_addr | input | AW | Transaction address |
| in_cmd | input | 4 | Bus command code |
| in_be | input | DW/8 | Byte enables |
| in_data | input | DW | Write data |
| rsp_valid | output | 1 | Response to last cycle's offer |
| rsp_code | output | 2 | 1 retry, 2 accept, 3 complete |
| rsp_data | output | DW | Read data with a complete response |
| out_valid | output | 1 | Transaction presented to destination bus |
| out_posted | output | 1 | Presented transaction is a posted write |
| out_addr | output | AW | Presented address |
| out_cmd | output | 4 | Presented command |
| out_be | output | DW/8 | Presented byte enables |
| out_data | output | DW | Presented write data |
| dst_done | input | 1 | Destination ended the presented transaction |
| dst_retry | input | 1 | That ending was a retry |
| dst_rdata | input | DW | Data returned with a non-retry ending |

## Verification
The assertions assume three things about the inputs. Inputs change only away from the clock edge. `dst_done` and `dst_retry` mean something only while `out_valid` is 1. No two different parked requests share the same address, command and byte enables. The stimulus draws delayed requests from a small set of distinct addresses, so repeats always find their own slot. It drives the destination responses from a fixed pseudo-random sequence that may end a transaction with or without retry. It also stalls the destination for a while so that the FIFO fills.

// File: rtl/br_ord_pkg.sv
package br_ord_pkg;
  typedef enum logic [1:0] {
    RSP_NONE   = 2'd0,
    RSP_RETRY  = 2'd1,
    RSP_ACCEPT = 2'd2,
    RSP_DONE   = 2'd3
  } rsp_e;

  typedef enum logic [1:0] {
    SL_FREE = 2'd0,
    SL_PEND = 2'd1,
    SL_BUSY = 2'd2,
    SL_DONE = 2'd3
  } slot_e;
endpackage

// File: rtl/br_pw_fifo.sv
module br_pw_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 72,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= step(wp);
      if (pop)  rp <= step(rp);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign rdata = mem[rp];
endmodule

// File: rtl/br_dr_slot.sv
module br_dr_slot
  import br_ord_pkg::*;
#(
  parameter int TW = 40,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          issue,
  input  logic          finish,
  input  logic          rel,
  input  logic [TW-1:0] tag_in,
  input  logic [DW-1:0] data_in,
  input  logic [DW-1:0] rdata_in,
  input  logic [TW-1:0] req_tag,
  output slot_e         state,
  output logic [TW-1:0] tag,
  output logic [DW-1:0] data,
  output logic [DW-1:0] rdata,
  output logic          hit
);
  assign hit = (state != SL_FREE) && (tag == req_tag);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SL_FREE;
    end else if (load && state == SL_FREE) begin
      state <= SL_PEND;
    end else if (issue && state == SL_PEND) begin
      state <= SL_BUSY;
    end else if (finish && state == SL_BUSY) begin
      state <= SL_DONE;
    end else if (rel && state == SL_DONE) begin
      state <= SL_FREE;
    end
  end

  always_ff @(posedge clk) begin
    if (load && state == SL_FREE) begin
      tag  <= tag_in;
      data <= data_in;
    end
    if (finish && state == SL_BUSY) rdata <= rdata_in;
  end
endmodule

// File: rtl/br_ord_queue.sv
module br_ord_queue
  import br_ord_pkg::*;
#(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int PW_DEPTH = 4,
  parameter int DR_SLOTS = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic            in_posted,
  input  logic [AW-1:0]   in_addr,
  input  logic [3:0]      in_cmd,
  input  logic [DW/8-1:0] in_be,
  input  logic [DW-1:0]   in_data,
  output logic            rsp_valid,
  output logic [1:0]      rsp_code,
  output logic [DW-1:0]   rsp_data,
  output logic            out_valid,
  output logic            out_posted,
  output logic [AW-1:0]   out_addr,
  output logic [3:0]      out_cmd,
  output logic [DW/8-1:0] out_be,
  output logic [DW-1:0]   out_data,
  input  logic            dst_done,
  input  logic            dst_retry,
  input  logic [DW-1:0]   dst_rdata
);
  localparam int CMD_W = 4;
  localparam int BE_W  = DW / 8;
  localparam int TW    = AW + CMD_W + BE_W;
  localparam int EW    = TW + DW;
  localparam int CW    = $clog2(PW_DEPTH + 1);
  localparam int SW    = (DR_SLOTS > 1) ? $clog2(DR_SLOTS) : 1;

  logic [TW-1:0] req_tag;
  logic [EW-1:0] pw_head;
  logic [CW-1:0] pw_count;
  logic          pw_full, pw_push, pw_pop;

  slot_e         sl_st   [DR_SLOTS];
  logic [TW-1:0] sl_tag  [DR_SLOTS];
  logic [DW-1:0] sl_data [DR_SLOTS];
  logic [DW-1:0] sl_rd   [DR_SLOTS];
  logic [DR_SLOTS-1:0] sl_hit, sl_load, sl_issue, sl_fin, sl_rel;

  logic          hit_any, free_any, pick_ok, take_pw, take_dr, finish;
  logic [SW-1:0] hit_idx, free_idx, pick, rr, out_slot;
  rsp_e          nxt_code, rsp_q;
  logic [DW-1:0] nxt_data;

  assign req_tag = {in_addr, in_cmd, in_be};
  assign pw_full = (pw_count == CW'(PW_DEPTH));

  br_pw_fifo #(.DEPTH(PW_DEPTH), .W(EW)) u_pw_fifo (
    .clk(clk), .rst(rst), .push(pw_push), .wdata({req_tag, in_data}),
    .pop(pw_pop), .rdata(pw_head), .count(pw_count)
  );

  for (genvar g = 0; g < DR_SLOTS; g++) begin : g_slot
    br_dr_slot #(.TW(TW), .DW(DW)) u_slot (
      .clk(clk), .rst(rst), .load(sl_load[g]), .issue(sl_issue[g]),
      .finish(sl_fin[g]), .rel(sl_rel[g]), .tag_in(req_tag),
      .data_in(in_data), .rdata_in(dst_rdata), .req_tag(req_tag),
      .state(sl_st[g]), .tag(sl_tag[g]), .data(sl_data[g]),
      .rdata(sl_rd[g]), .hit(sl_hit[g])
    );
  end

  // originating-side decision
  always_comb begin
    hit_any  = 1'b0;
    hit_idx  = '0;
    free_any = 1'b0;
    free_idx = '0;
    for (int i = DR_SLOTS - 1; i >= 0; i--) begin
      if (sl_hit[i]) begin
        hit_any = 1'b1;
        hit_idx = SW'(i);
      end
      if (sl_st[i] == SL_FREE) begin
        free_any = 1'b1;
        free_idx = SW'(i);
      end
    end
    pw_push  = 1'b0;
    sl_load  = '0;
    sl_rel   = '0;
    nxt_code = RSP_NONE;
    nxt_data = '0;
    if (in_valid) begin
      if (in_posted) begin
        nxt_code = pw_full ? RSP_RETRY : RSP_ACCEPT;
        pw_push  = !pw_full;
      end else if (hit_any) begin
        if (sl_st[hit_idx] == SL_DONE) begin
          nxt_code         = RSP_DONE;
          nxt_data         = sl_rd[hit_idx];
          sl_rel[hit_idx]  = 1'b1;
        end else begin
          nxt_code = RSP_RETRY;
        end
      end else begin
        nxt_code = RSP_RETRY;
        if (free_any) sl_load[free_idx] = 1'b1;
      end
    end
  end

  // destination-side issue selection
  always_comb begin
    pick_ok = 1'b0;
    pick    = '0;
    for (int k = 0; k < DR_SLOTS; k++) begin
      int idx;
      idx = (int'(rr) + k) % DR_SLOTS;
      if (!pick_ok && sl_st[idx] == SL_PEND) begin
        pick_ok = 1'b1;
        pick    = SW'(idx);
      end
    end
    take_pw = !out_valid && (pw_count != '0);
    take_dr = !out_valid && (pw_count == '0) && pick_ok;
    finish  = out_valid && dst_done && !dst_retry;
    pw_pop  = finish && out_posted;
    for (int i = 0; i < DR_SLOTS; i++) begin
      sl_issue[i] = take_dr && (pick == SW'(i));
      sl_fin[i]   = finish && !out_posted && (out_slot == SW'(i));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_q      <= RSP_NONE;
      rsp_data   <= '0;
      out_valid  <= 1'b0;
      out_posted <= 1'b0;
      out_slot   <= '0;
      rr         <= '0;
    end else begin
      rsp_valid <= in_valid;
      rsp_q     <= nxt_code;
      rsp_data  <= nxt_data;
      if (finish) begin
        out_valid <= 1'b0;
      end else if (take_pw) begin
        out_valid  <= 1'b1;
        out_posted <= 1'b1;
      end else if (take_dr) begin
        out_valid  <= 1'b1;
        out_posted <= 1'b0;
        out_slot   <= pick;
        rr         <= (int'(pick) == DR_SLOTS - 1) ? '0 : pick + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (take_pw) begin
      {out_addr, out_cmd, out_be, out_data} <= pw_head;
    end else if (take_dr) begin
      {out_addr, out_cmd, out_be} <= sl_tag[pick];
      out_data                    <= sl_data[pick];
    end
  end

  assign rsp_code = rsp_q;
endmodule

// File: rtl/br_ord_checker.sv
module br_ord_checker #(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int PW_DEPTH = 4,
  localparam int CW      = $clog2(PW_DEPTH + 1)
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic            in_posted,
  input logic            rsp_valid,
  input logic [1:0]      rsp_code,
  input logic            out_valid,
  input logic            out_posted,
  input logic [AW-1:0]   out_addr,
  input logic [DW/8-1:0] out_be,
  input logic [DW-1:0]   out_data,
  input logic            dst_done,
  input logic            dst_retry,
  input logic [CW-1:0]   pw_count
);
  a_r2_accept_when_room: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_posted && (pw_count != CW'(PW_DEPTH))
    |=> rsp_valid && rsp_code == 2'd2);

  a_r3_retry_when_full: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_posted && (pw_count == CW'(PW_DEPTH))
    |=> rsp_valid && rsp_code == 2'd1);

  a_r5_posted_first: assert property (@(posedge clk) disable iff (rst)
    !out_valid && (pw_count != '0) |=> out_valid && out_posted);

  a_r9_no_complete_for_write: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_posted |=> rsp_code != 2'd3);

  a_r10_hold_on_retry: assert property (@(posedge clk) disable iff (rst)
    out_valid && (!dst_done || dst_retry)
    |=> out_valid && $stable(out_posted) && $stable(out_addr)
        && $stable(out_be) && $stable(out_data));

  a_r13_rsp_follows_req: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> rsp_valid);

  a_r13_no_rsp_without_req: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !rsp_valid);
endmodule

bind br_ord_queue br_ord_checker #(.AW(AW), .DW(DW), .PW_DEPTH(PW_DEPTH)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_posted(in_posted),
  .rsp_valid(rsp_valid), .rsp_code(rsp_code), .out_valid(out_valid),
  .out_posted(out_posted), .out_addr(out_addr), .out_be(out_be),
  .out_data(out_data), .dst_done(dst_done), .dst_retry(dst_retry),
  .pw_count(pw_count)
);

// File: tb/br_ord_queue_tb_top.sv
module br_ord_queue_tb_top;
  localparam int AW = 32, DW = 32, DEPTH = 4, NS = 2, EW = 72;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1;
  logic in_valid = 1'b0, in_posted = 1'b0;
  logic [31:0] in_addr = '0, in_data = '0;
  logic [3:0]  in_cmd = '0, in_be = '0;
  logic rsp_valid, out_valid, out_posted;
  logic [1:0]  rsp_code;
  logic [31:0] rsp_data, out_addr, out_data;
  logic [3:0]  out_cmd, out_be;
  logic dst_done = 1'b0, dst_retry = 1'b0;
  logic [31:0] dst_rdata = '0;

  br_ord_queue #(.AW(AW), .DW(DW), .PW_DEPTH(DEPTH), .DR_SLOTS(NS)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_posted(in_posted),
    .in_addr(in_addr), .in_cmd(in_cmd), .in_be(in_be), .in_data(in_data),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_data(rsp_data),
    .out_valid(out_valid), .out_posted(out_posted), .out_addr(out_addr),
    .out_cmd(out_cmd), .out_be(out_be), .out_data(out_data),
    .dst_done(dst_done), .dst_retry(dst_retry), .dst_rdata(dst_rdata)
  );

  int tests = 0, fails = 0, cyc = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [EW-1:0] act, input logic [EW-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // reference model state
  logic [EW-1:0] mq[$];
  int m_st[NS];
  int m_bar[NS];
  logic [39:0] m_tag[NS];
  logic [31:0] m_dat[NS], m_rd[NS];
  int m_rr, m_os, acc_cnt, port_done, last_bar;
  bit m_ov, m_op, e_rv;
  logic [EW-1:0] m_oe;
  logic [1:0] e_code;
  logic [31:0] e_data;
  string e_tag, m_otag;
  int lat, rel, hit, fr;
  bit push;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      fails++;
      $display("FAIL R13 watchdog actual=%0d expected=%0d", cyc, 50000);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
    if (rst) begin
      mq.delete();
      for (int i = 0; i < NS; i++) m_st[i] = 0;
      m_rr = 0; m_ov = 0; e_rv = 0; acc_cnt = 0; port_done = 0;
    end else begin
      if (out_valid && dst_done && !dst_retry && out_posted) port_done++;
      e_rv = in_valid; e_code = 2'd0; e_data = '0;
      push = 0; lat = -1; rel = -1; hit = -1; fr = -1;
      if (in_valid) begin
        if (in_posted) begin
          if (mq.size() < DEPTH) begin push = 1; e_code = 2'd2; e_tag = "R2"; end
          else begin e_code = 2'd1; e_tag = "R3"; end
        end else begin
          for (int i = NS - 1; i >= 0; i--) begin
            if (m_st[i] != 0 && m_tag[i] == {in_addr, in_cmd, in_be}) hit = i;
            if (m_st[i] == 0) fr = i;
          end
          if (hit >= 0) begin
            if (m_st[hit] == 3) begin
              e_code = 2'd3; e_data = m_rd[hit]; rel = hit; e_tag = "R9";
              last_bar = m_bar[hit];
            end else begin e_code = 2'd1; e_tag = "R8"; end
          end else if (fr >= 0) begin
            lat = fr; e_code = 2'd1; e_tag = "R6";
          end else begin e_code = 2'd1; e_tag = "R7"; end
        end
      end
      if (m_ov) begin
        if (dst_done) begin
          if (dst_retry) m_otag = "R10";
          else begin
            m_ov = 0;
            if (m_op) void'(mq.pop_front());
            else begin m_st[m_os] = 3; m_rd[m_os] = dst_rdata; end
          end
        end
      end else if (mq.size() > 0) begin
        m_ov = 1; m_op = 1; m_oe = mq[0]; m_otag = "R4";
      end else begin
        for (int k = 0; k < NS; k++) begin
          int idx;
          idx = (m_rr + k) % NS;
          if (!m_ov && m_st[idx] == 1) begin
            m_ov = 1; m_op = 0; m_os = idx; m_st[idx] = 2;
            m_oe = {m_tag[idx], m_dat[idx]}; m_otag = "R11";
            m_rr = (idx + 1) % NS;
          end
        end
      end
      if (push) begin mq.push_back({in_addr, in_cmd, in_be, in_data}); acc_cnt++; end
      if (lat >= 0) begin
        m_st[lat] = 1; m_tag[lat] = {in_addr, in_cmd, in_be};
        m_dat[lat] = in_data; m_bar[lat] = acc_cnt;
      end
      if (rel >= 0) m_st[rel] = 0;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk(rsp_valid === e_rv, "R13", "rsp_valid", EW'(rsp_valid), EW'(e_rv));
      if (e_rv) begin
        chk(rsp_code === e_code, e_tag, "rsp_code", EW'(rsp_code), EW'(e_code));
        if (e_code == 2'd3) begin
          chk(rsp_data === e_data, "R9", "rsp_data", EW'(rsp_data), EW'(e_data));
          chk(port_done >= last_bar, "R12", "writes finished before completion",
              EW'(port_done), EW'(last_bar));
        end
      end
      chk(out_valid === m_ov, "R5", "out_valid", EW'(out_valid), EW'(m_ov));
      if (m_ov) begin
        chk(out_posted === m_op, m_otag, "out_posted", EW'(out_posted), EW'(m_op));
        chk({out_addr, out_cmd, out_be, out_data} === m_oe, m_otag, "out fields",
            {out_addr, out_cmd, out_be, out_data}, m_oe);
      end
    end
  end

  // destination responder: 0 stall, 1 finish every cycle, 2 pseudo-random
  int dst_mode = 0;
  logic [31:0] lf = 32'h1234_5678;
  function automatic logic [31:0] rnd();
    lf = lf ^ (lf << 13);
    lf = lf ^ (lf >> 17);
    lf = lf ^ (lf << 5);
    return lf;
  endfunction

  always @(negedge clk) begin
    logic [31:0] r;
    #1;
    r = rnd();
    case (dst_mode)
      0: dst_done = 1'b0;
      1: begin dst_done = 1'b1; dst_retry = 1'b0; end
      default: begin dst_done = r[0]; dst_retry = r[1] & r[2]; end
    endcase
    dst_rdata = 32'hD000_0000 ^ cyc;
  end

  task automatic req(input bit p, input logic [31:0] a, input logic [3:0] c,
                     input logic [3:0] b, input logic [31:0] d);
    @(negedge clk); #2;
    in_valid = 1'b1; in_posted = p; in_addr = a; in_cmd = c; in_be = b; in_data = d;
    @(negedge clk); #2;
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(3);
    #2 rst = 1'b0;
    @(negedge clk);
    chk(out_valid === 1'b0, "R1", "out_valid after reset", EW'(out_valid), '0);
    chk(rsp_valid === 1'b0, "R1", "rsp_valid after reset", EW'(rsp_valid), '0);

    // R3/R4: fill FIFO with writes to one address, stalled destination
    dst_mode = 0;
    for (int i = 0; i < 5; i++) req(1'b1, 32'h40, 4'h7, 4'(1 << (i % 4)), 32'hA0 + i);
    idle(4);
    dst_mode = 1;
    idle(12);

    // R5-R9, R11: write ahead of delayed requests, slots fill
    dst_mode = 0;
    req(1'b1, 32'h80, 4'h7, 4'hF, 32'h55);
    req(1'b0, 32'h100, 4'h6, 4'hF, 32'h0);
    req(1'b0, 32'h100, 4'h6, 4'hF, 32'h0);
    req(1'b0, 32'h104, 4'h6, 4'h3, 32'h0);
    req(1'b0, 32'h108, 4'h6, 4'hF, 32'h0);
    dst_mode = 1;
    idle(10);
    req(1'b0, 32'h108, 4'h6, 4'hF, 32'h0);
    req(1'b0, 32'h100, 4'h6, 4'hF, 32'h0);
    req(1'b0, 32'h108, 4'h6, 4'hF, 32'h0);
    req(1'b0, 32'h104, 4'h6, 4'h3, 32'h0);
    idle(6);
    req(1'b0, 32'h108, 4'h6, 4'hF, 32'h0);

    // mixed traffic with destination retries (R2, R10, R12)
    dst_mode = 2;
    for (int n = 0; n < 600; n++) begin
      logic [31:0] r;
      r = rnd();
      if (n % 150 == 0) dst_mode = 0;
      if (n % 150 == 20) dst_mode = 2;
      if (r[3:0] < 4'd6)
        req(1'b1, {r[31:20], 20'h0}, 4'h7, r[7:4] | 4'h1, r);
      else
        req(1'b0, 32'h100 + 32'(4 * (r[9:8] % 3)), 4'h6, 4'hF, 32'h0);
    end
    dst_mode = 1;
    idle(30);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule